// File: doc/BRIEF.md
# Control Decoder with Stuck-at-0 Fault Injection

This block turns the opcode and function field of a small single-cycle load/store processor into the control lines that steer its datapath. It supports five instructions: add, addi, lw, sw and beq. It also takes the ALU zero flag, so that the next-PC select can be resolved for a branch. The outputs are the register-write enable, the ALU operand-B select (immediate or register), the memory read and write strobes, the write-back source select (memory or ALU), the next-PC select and a two-bit ALU operation code. The register file, the memories and the ALU are outside this block.

A four-bit fault mask can pin any of four control lines at 0, whatever the decode produced. Those lines are the write-back source select, the next-PC select, the memory write strobe and the ALU operand-B select. A status output, `instr_broken`, flags each instruction that the injected fault corrupts. A test environment can therefore sort instructions into those that still run and those that break under each single fault.

All outputs are registered. They show the decode of the inputs sampled at one rising clock edge from that edge until the next.

Top module: `ctl_fault_unit`

## Requirements
- R1: While `rst_n` is low, every output is 0. After reset, each output shows the decode of the inputs sampled at the previous rising edge, so the latency is one cycle.
- R2: Opcode 000000 with funct 100000 (add) gives reg_wr=1 and alu_op=10. All other control lines are 0.
- R3: Opcode 100011 (lw) gives reg_wr=1, alu_imm_sel=1, mem_rd=1, wb_from_mem=1 and alu_op=00. mem_wr and pc_take are 0.
- R4: Opcode 101011 (sw) gives alu_imm_sel=1, mem_wr=1 and alu_op=00. reg_wr, mem_rd, wb_from_mem and pc_take are 0.
- R5: Opcode 001000 (addi) gives reg_wr=1, alu_imm_sel=1 and alu_op=00. The other lines are 0.
- R6: Opcode 000100 (beq) gives alu_op=01, and pc_take equals alu_zero. The other lines are 0.
- R7: Any other opcode, and opcode 000000 with a funct other than 100000, drives every output to 0.
- R8: stuck_mask bit 0 forces wb_from_mem to 0. Among the five instructions, only lw is reported broken.
- R9: stuck_mask bit 1 forces pc_take to 0. Only a beq with alu_zero=1 is reported broken; a beq with alu_zero=0 is not.
- R10: stuck_mask bit 2 forces mem_wr to 0. Only sw is reported broken.
- R11: stuck_mask bit 3 forces alu_imm_sel to 0. lw, addi and sw are reported broken; add and beq are not.
- R12: instr_broken is 1 exactly when a masked line would have decoded to 1. Lines that no mask bit covers keep their decoded values under any mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Function field for register-format instructions |
| alu_zero | input | 1 | ALU equality result for a branch |
| stuck_mask | input | 4 | Stuck-at-0 injection: bit0 wb_from_mem, bit1 pc_take, bit2 mem_wr, bit3 alu_imm_sel |
| reg_wr | output | 1 | Register file write enable |
| alu_imm_sel | output | 1 | ALU operand B takes the sign-extended immediate |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| wb_from_mem | output | 1 | Write-back data taken from memory |
| pc_take | output | 1 | Next PC is the branch target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract-compare, 10 use funct |
| instr_broken | output | 1 | The current instruction is corrupted by the injected fault |

## Verification
The bench sweeps each single-bit fault over all five instructions and compares the set of broken instructions against the expected classes. A design that wires a mask bit to the wrong line would report the wrong instruction set under that fault. A beq with the flag clear is run under the next-PC fault: a design that flags the branch without looking at alu_zero would wrongly report it broken. An all-ones mask checks that reg_wr, mem_rd and alu_op survive, since a mask that leaked into lines it does not cover would corrupt them. Undecodable opcodes and a non-add funct must give all zeros, which a decoder looking only at the opcode would fail. A reset asserted in the middle of a run must clear the registered outputs within one edge.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int N_FAULT = 4;
    localparam int AOP_W   = 2;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [FN_W-1:0]  FN_ADD    = 6'b100000;

    localparam logic [AOP_W-1:0] AOP_ADD = 2'b00;
    localparam logic [AOP_W-1:0] AOP_SUB = 2'b01;
    localparam logic [AOP_W-1:0] AOP_FN  = 2'b10;

    // positions of the faultable lines inside the fault vector
    localparam int FL_WB  = 0;
    localparam int FL_PC  = 1;
    localparam int FL_MW  = 2;
    localparam int FL_IMM = 3;

    typedef struct packed {
        logic             reg_wr;
        logic             alu_imm_sel;
        logic             mem_rd;
        logic             mem_wr;
        logic             wb_from_mem;
        logic             pc_take;
        logic [AOP_W-1:0] alu_op;
        logic             broken;
    } ctl_word_t;
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic             alu_zero,
    output ctl_word_t        raw
);
    always_comb begin
        raw = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADD) begin
                    raw.reg_wr = 1'b1;
                    raw.alu_op = AOP_FN;
                end
            end
            OPC_LW: begin
                raw.reg_wr      = 1'b1;
                raw.alu_imm_sel = 1'b1;
                raw.mem_rd      = 1'b1;
                raw.wb_from_mem = 1'b1;
                raw.alu_op      = AOP_ADD;
            end
            OPC_SW: begin
                raw.alu_imm_sel = 1'b1;
                raw.mem_wr      = 1'b1;
                raw.alu_op      = AOP_ADD;
            end
            OPC_ADDI: begin
                raw.reg_wr      = 1'b1;
                raw.alu_imm_sel = 1'b1;
                raw.alu_op      = AOP_ADD;
            end
            OPC_BEQ: begin
                raw.pc_take = alu_zero;
                raw.alu_op  = AOP_SUB;
            end
            default: raw = '0;
        endcase
    end
endmodule

// File: rtl/ctl_stuck_mask.sv
module ctl_stuck_mask
    import ctl_pkg::*;
(
    input  ctl_word_t          raw,
    input  logic [N_FAULT-1:0] stuck_mask,
    output ctl_word_t          forced
);
    logic [N_FAULT-1:0] lines_in;
    logic [N_FAULT-1:0] lines_out;
    logic [N_FAULT-1:0] hit;

    always_comb begin
        lines_in         = '0;
        lines_in[FL_WB]  = raw.wb_from_mem;
        lines_in[FL_PC]  = raw.pc_take;
        lines_in[FL_MW]  = raw.mem_wr;
        lines_in[FL_IMM] = raw.alu_imm_sel;
    end

    for (genvar i = 0; i < N_FAULT; i++) begin : g_line
        assign lines_out[i] = lines_in[i] & ~stuck_mask[i];
        assign hit[i]       = lines_in[i] &  stuck_mask[i];
    end

    always_comb begin
        forced             = raw;
        forced.wb_from_mem = lines_out[FL_WB];
        forced.pc_take     = lines_out[FL_PC];
        forced.mem_wr      = lines_out[FL_MW];
        forced.alu_imm_sel = lines_out[FL_IMM];
        forced.broken      = |hit;
    end
endmodule

// File: rtl/ctl_fault_unit.sv
module ctl_fault_unit
    import ctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [5:0]   opcode,
    input  logic [5:0]   funct,
    input  logic         alu_zero,
    input  logic [3:0]   stuck_mask,
    output logic         reg_wr,
    output logic         alu_imm_sel,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         wb_from_mem,
    output logic         pc_take,
    output logic [1:0]   alu_op,
    output logic         instr_broken
);
    ctl_word_t raw_w;
    ctl_word_t ctl_d;
    ctl_word_t ctl_q;

    ctl_decode u_dec (
        .opcode   (opcode),
        .funct    (funct),
        .alu_zero (alu_zero),
        .raw      (raw_w)
    );

    ctl_stuck_mask u_mask (
        .raw        (raw_w),
        .stuck_mask (stuck_mask),
        .forced     (ctl_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign reg_wr       = ctl_q.reg_wr;
    assign alu_imm_sel  = ctl_q.alu_imm_sel;
    assign mem_rd       = ctl_q.mem_rd;
    assign mem_wr       = ctl_q.mem_wr;
    assign wb_from_mem  = ctl_q.wb_from_mem;
    assign pc_take      = ctl_q.pc_take;
    assign alu_op       = ctl_q.alu_op;
    assign instr_broken = ctl_q.broken;

    // R9
    branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_take |-> ($past(opcode) == OPC_BEQ && $past(alu_zero) && !$past(stuck_mask[FL_PC])));
    // R10
    store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(opcode) == OPC_SW && !$past(stuck_mask[FL_MW])));
    // R3
    wb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_from_mem |-> (mem_rd && reg_wr));
    // R4
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
    // R11
    imm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_imm_sel |-> !$past(stuck_mask[FL_IMM]));
    // R12
    broken_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_broken |-> ($past(stuck_mask) != '0));
    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(opcode) == 6'b111111) |-> (!reg_wr && !mem_rd && alu_op == 2'b00));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!reg_wr && !mem_rd && !mem_wr && !pc_take && !instr_broken));
endmodule

// File: tb/tb_ctl_fault_unit.sv
module tb_ctl_fault_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       alu_zero = 1'b0;
    logic [3:0] stuck_mask = '0;
    logic       reg_wr, alu_imm_sel, mem_rd, mem_wr, wb_from_mem, pc_take, instr_broken;
    logic [1:0] alu_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctl_fault_unit dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
        .alu_zero(alu_zero), .stuck_mask(stuck_mask),
        .reg_wr(reg_wr), .alu_imm_sel(alu_imm_sel), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .wb_from_mem(wb_from_mem), .pc_take(pc_take),
        .alu_op(alu_op), .instr_broken(instr_broken)
    );

    localparam logic [5:0] ADD_OP = 6'b000000, LW = 6'b100011, SW = 6'b101011,
                           BEQ = 6'b000100, ADDI = 6'b001000, FADD = 6'b100000;

    // stimulus {opcode, funct, zero, mask} ; expected {rw,imm,mrd,mwr,wb,pc,aop[1:0],brk}
    localparam int NV = 21;
    localparam logic [25:0] VEC [NV] = '{
        {ADD_OP, FADD,    1'b0, 4'b0000, 9'b1_0_0_0_0_0_10_0},  // R2
        {LW,     6'd0,    1'b0, 4'b0000, 9'b1_1_1_0_1_0_00_0},  // R3
        {SW,     6'd0,    1'b0, 4'b0000, 9'b0_1_0_1_0_0_00_0},  // R4
        {BEQ,    6'd0,    1'b1, 4'b0000, 9'b0_0_0_0_0_1_01_0},  // R6
        {BEQ,    6'd0,    1'b0, 4'b0000, 9'b0_0_0_0_0_0_01_0},  // R6
        {ADDI,   6'd0,    1'b0, 4'b0000, 9'b1_1_0_0_0_0_00_0},  // R5
        {LW,     6'd0,    1'b0, 4'b0001, 9'b1_1_1_0_0_0_00_1},  // R8
        {ADD_OP, FADD,    1'b0, 4'b0001, 9'b1_0_0_0_0_0_10_0},  // R8
        {BEQ,    6'd0,    1'b1, 4'b0010, 9'b0_0_0_0_0_0_01_1},  // R9
        {SW,     6'd0,    1'b0, 4'b0010, 9'b0_1_0_1_0_0_00_0},  // R9
        {SW,     6'd0,    1'b0, 4'b0100, 9'b0_1_0_0_0_0_00_1},  // R10
        {LW,     6'd0,    1'b0, 4'b0100, 9'b1_1_1_0_1_0_00_0},  // R10
        {LW,     6'd0,    1'b0, 4'b1000, 9'b1_0_1_0_1_0_00_1},  // R11
        {ADDI,   6'd0,    1'b0, 4'b1000, 9'b1_0_0_0_0_0_00_1},  // R11
        {ADD_OP, FADD,    1'b0, 4'b1000, 9'b1_0_0_0_0_0_10_0},  // R11
        {BEQ,    6'd0,    1'b1, 4'b1000, 9'b0_0_0_0_0_1_01_0},  // R11
        {BEQ,    6'd0,    1'b0, 4'b0010, 9'b0_0_0_0_0_0_01_0},  // R9
        {6'b111111, 6'd0, 1'b1, 4'b0000, 9'b0_0_0_0_0_0_00_0},  // R7
        {ADD_OP, 6'b100010, 1'b0, 4'b0000, 9'b0_0_0_0_0_0_00_0},// R7
        {SW,     6'd0,    1'b0, 4'b1111, 9'b0_0_0_0_0_0_00_1},  // R12
        {ADD_OP, FADD,    1'b0, 4'b1111, 9'b1_0_0_0_0_0_10_0}   // R12
    };

    function automatic logic [8:0] outs();
        return {reg_wr, alu_imm_sel, mem_rd, mem_wr, wb_from_mem, pc_take, alu_op, instr_broken};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] op, input logic [5:0] fn, input logic z, input logic [3:0] m);
        @(negedge clk);
        opcode = op; funct = fn; alu_zero = z; stuck_mask = m;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [5:0] iop [5];
        logic [4:0] exp_set [4];
        logic [4:0] got;
        iop[0] = ADD_OP; iop[1] = LW; iop[2] = ADDI; iop[3] = BEQ; iop[4] = SW;
        exp_set[0] = 5'b00010; exp_set[1] = 5'b01000;
        exp_set[2] = 5'b10000; exp_set[3] = 5'b10110;

        // R1: outputs held at zero in reset even with lw presented
        opcode = LW;
        repeat (3) @(negedge clk);
        check("R1 reset", outs(), 9'b0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][25:20], VEC[i][19:14], VEC[i][13], VEC[i][12:9]);
            check($sformatf("vec %0d", i), outs(), VEC[i][8:0]);
        end

        // R8 R9 R10 R11: broken-instruction classes per single fault
        for (int m = 0; m < 4; m++) begin
            got = '0;
            for (int k = 0; k < 5; k++) begin
                drive(iop[k], FADD, 1'b1, 4'(1 << m));
                got[k] = instr_broken;
            end
            check($sformatf("R8_R11 class mask bit %0d", m), {4'b0, got}, {4'b0, exp_set[m]});
        end

        // R1: reset in mid-run clears the registered lw decode
        drive(LW, 6'd0, 1'b0, 4'b0000);
        check("R1 lw before reset", outs(), 9'b1_1_1_0_1_0_00_0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", outs(), 9'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 one-cycle latency after reset", outs(), 9'b1_1_1_0_1_0_00_0);

        finish_run();
    end
endmodule